// File: doc/BRIEF.md
# Self-Correcting Triplicated Register with Scan Observation

This block is a register slice held in three redundant copies. Each copy has its own data input. A majority voter sits in front of each copy's flip-flops. It takes the three copies' next-state inputs, bit by bit, and returns the voted value to that copy's flip-flops. A single-copy disagreement therefore never reaches any register output. A copy whose flip-flop has been upset is overwritten with the voted value at the next clock edge.

The voting hides faults, so each copy also carries a scan chain of capture/shift cells. The chain samples every flip-flop output and every flip-flop input (the voter output) on the system clock. The three chains shift in parallel, one per copy. An external comparing controller can read them side by side and see which copy disagrees. The scan cells have no output latch and only observe the functional path, never drive it.

Top module: `tmr_scan_reg`

## Requirements
- R1: A synchronous active-high reset clears the flip-flops of all three copies and every scan cell to zero. After release, each chain shifts out zeros until scan-in data arrives.
- R2: One clock edge after data is applied, each copy's register output equals the bitwise majority of the three copies' data inputs. This holds even when all three inputs differ.
- R3: A data input that disagrees in one copy only has no effect on any register output.
- R4: On every cycle after reset, the three copies' register outputs are identical.
- R5: When capture is enabled, each chain loads as follows. Cell k (k < WIDTH) takes that copy's flip-flop output bit k as it was before the edge. Cell WIDTH+k takes the voted value being loaded into bit k. Scan-out always presents cell 0.
- R6: When shift is enabled and capture is not, every cell takes the value of its neighbour one position higher. The highest cell takes scan-in, so after k shifts scan-out shows the captured cell k.
- R7: When capture and shift are both enabled, the cells capture and do not shift.
- R8: Capturing and shifting have no effect on the register outputs.
- R9: Each copy's chain shifts its own scan-in to its own scan-out, independently of the other two chains.
- R10: With both enables low, the scan cells keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also clocks the scan cells |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 3 x WIDTH | Data input of each copy (index 0..2) |
| cap_en | input | 1 | Capture enable for all scan cells |
| shift_en | input | 1 | Shift enable for all scan cells |
| scan_in | input | 3 | Serial input of each copy's chain |
| q | output | 3 x WIDTH | Register output of each copy |
| scan_out | output | 3 | Serial output of each copy's chain (cell 0) |

## Verification
Every result is registered. Register outputs and scan-out change at the first rising edge after the inputs that cause them are applied. This covers a new register value, a capture, a single shift step and a hold. Serial data from scan-in reaches scan-out only after 2*WIDTH shift edges. The driver applies stimulus on the falling edge and queues the expected outputs with a due cycle one edge later. The monitor compares them on the following falling edge, so nothing is sampled at the edge that updates it. For a shift sequence, the expected scan-out for each step is computed from the register value held before capture and the voted value loaded at capture.

// File: rtl/tmr_scan_pkg.sv
package tmr_scan_pkg;

    localparam int NCOPY = 3;

    typedef enum logic [1:0] {
        SCAN_HOLD    = 2'd0,
        SCAN_SHIFT   = 2'd1,
        SCAN_CAPTURE = 2'd2
    } scan_op_e;

    // bitwise two-of-three vote
    function automatic logic maj3(logic a, logic b, logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // capture wins over shift
    function automatic scan_op_e scan_decode(logic cap, logic sh);
        if (cap)
            return SCAN_CAPTURE;
        else if (sh)
            return SCAN_SHIFT;
        else
            return SCAN_HOLD;
    endfunction

endpackage

// File: rtl/tmr_maj_voter.sv
module tmr_maj_voter
    import tmr_scan_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [NCOPY-1:0][WIDTH-1:0] vin,
    output logic [WIDTH-1:0]            vout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign vout[b] = maj3(vin[0][b], vin[1][b], vin[2][b]);
    end

endmodule

// File: rtl/tmr_flop_copy.sv
module tmr_flop_copy #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

    // R1: reset clears the copy
    p_reset_zero_r1: assert property (@(posedge clk) rst |=> q == '0)
        else $error("p_reset_zero_r1");

endmodule

// File: rtl/tmr_scan_chain.sv
module tmr_scan_chain
    import tmr_scan_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  scan_op_e         op,
    input  logic [WIDTH-1:0] obs_q,
    input  logic [WIDTH-1:0] obs_d,
    input  logic             si,
    output logic             so
);

    localparam int LEN = 2 * WIDTH;

    logic [LEN-1:0] cells;

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= '0;
        end else begin
            case (op)
                SCAN_CAPTURE: cells <= {obs_d, obs_q};
                SCAN_SHIFT:   cells <= {si, cells[LEN-1:1]};
                default:      cells <= cells;
            endcase
        end
    end

    assign so = cells[0];

    // R1: reset clears all cells
    p_chain_reset_r1: assert property (@(posedge clk) rst |=> cells == '0)
        else $error("p_chain_reset_r1");

    // R5: capture presents flip-flop output bit 0 at scan-out
    p_capture_head_r5: assert property (@(posedge clk) disable iff (rst)
        op == SCAN_CAPTURE |=> so == $past(obs_q[0]))
        else $error("p_capture_head_r5");

    // R6: shift moves the next cell to scan-out
    p_shift_step_r6: assert property (@(posedge clk) disable iff (rst)
        op == SCAN_SHIFT |=> so == $past(cells[1]))
        else $error("p_shift_step_r6");

    // R9: own scan-in enters the top cell
    p_shift_entry_r9: assert property (@(posedge clk) disable iff (rst)
        op == SCAN_SHIFT |=> cells[LEN-1] == $past(si))
        else $error("p_shift_entry_r9");

    // R10: idle cells hold
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        op == SCAN_HOLD |=> $stable(cells))
        else $error("p_hold_r10");

endmodule

// File: rtl/tmr_scan_reg.sv
module tmr_scan_reg
    import tmr_scan_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCOPY-1:0][WIDTH-1:0] din,
    input  logic                        cap_en,
    input  logic                        shift_en,
    input  logic [NCOPY-1:0]            scan_in,
    output logic [NCOPY-1:0][WIDTH-1:0] q,
    output logic [NCOPY-1:0]            scan_out
);

    scan_op_e                    op;
    logic [NCOPY-1:0][WIDTH-1:0] vote;

    assign op = scan_decode(cap_en, shift_en);

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        tmr_maj_voter #(.WIDTH(WIDTH)) u_voter (
            .vin  (din),
            .vout (vote[c])
        );

        tmr_flop_copy #(.WIDTH(WIDTH)) u_flop (
            .clk (clk),
            .rst (rst),
            .d   (vote[c]),
            .q   (q[c])
        );

        tmr_scan_chain #(.WIDTH(WIDTH)) u_chain (
            .clk   (clk),
            .rst   (rst),
            .op    (op),
            .obs_q (q[c]),
            .obs_d (vote[c]),
            .si    (scan_in[c]),
            .so    (scan_out[c])
        );

        // R2, R3, R8: each copy loads the vote of all data inputs
        p_vote_load_r2: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> q[c] == (($past(din[0]) & $past(din[1])) |
                              ($past(din[0]) & $past(din[2])) |
                              ($past(din[1]) & $past(din[2]))))
            else $error("p_vote_load_r2");
    end

    // R4: copies never diverge
    p_copies_agree_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q[0] == q[1]) && (q[1] == q[2]))
        else $error("p_copies_agree_r4");

    // R7: capture wins when both enables are high
    p_capture_first_r7: assert property (@(posedge clk) disable iff (rst)
        cap_en && shift_en |=> scan_out[0] == $past(q[0][0]))
        else $error("p_capture_first_r7");

endmodule

// File: tb/tmr_scan_reg_tb.sv
module tmr_scan_reg_tb;
    import tmr_scan_pkg::*;

    localparam int  W          = 8;
    localparam int  L          = 2 * W;
    localparam time CLK_PERIOD = 10;

    typedef logic [NCOPY-1:0][W-1:0] qv_t;
    typedef struct {
        int               due;
        string            req;
        qv_t              q;
        logic [NCOPY-1:0] so;
        bit               chk_so;
    } exp_t;

    exp_t sb[$];

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    qv_t              din = '0;
    logic             cap_en = 1'b0;
    logic             shift_en = 1'b0;
    logic [NCOPY-1:0] scan_in = '0;
    qv_t              q;
    logic [NCOPY-1:0] scan_out;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_scan_reg #(.WIDTH(W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .scan_in  (scan_in),
        .q        (q),
        .scan_out (scan_out)
    );

    function automatic logic [W-1:0] vote(qv_t v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    function automatic qv_t all3(logic [W-1:0] x);
        return {x, x, x};
    endfunction

    // monitor: compare due items on the falling edge
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            e = sb.pop_front();
            checks++;
            if (q !== e.q || (e.chk_so && scan_out !== e.so)) begin
                errors++;
                $display("FAIL %s: q=%h scan_out=%b expected q=%h scan_out=%b",
                         e.req, q, scan_out, e.q, e.so);
            end
        end
    end

    // driver: apply inputs, queue expectation for the next edge
    task automatic step(qv_t d, logic c, logic s, logic [NCOPY-1:0] si,
                        qv_t eq, logic [NCOPY-1:0] eso, bit chk, string req);
        din      = d;
        cap_en   = c;
        shift_en = s;
        scan_in  = si;
        sb.push_back('{cyc + 1, req, eq, eso, chk});
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0]   a_val;
        logic [W-1:0]   b_val;
        logic [W-1:0]   c_val;
        logic [L-1:0]   img;
        qv_t            mix;
        a_val = 8'h96;
        b_val = 8'h6B;
        c_val = 8'h10;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: outputs and chains cleared
        step('0, 1'b0, 1'b0, 3'b000, '0, 3'b000, 1'b1, "R1 reset state");
        for (int k = 1; k < L; k++)
            step('0, 1'b0, 1'b1, 3'b101, '0, 3'b000, 1'b1, "R1 chain zero after reset");
        step('0, 1'b0, 1'b1, 3'b101, '0, 3'b101, 1'b1, "R6 scan-in after full shift");

        // R2: unanimous loads
        step(all3(8'h5A), 1'b0, 1'b0, 3'b000, all3(8'h5A), 3'b000, 1'b0, "R2 load 5A");
        step(all3(8'hC3), 1'b0, 1'b0, 3'b000, all3(8'hC3), 3'b000, 1'b0, "R2 load C3");

        // R3: one copy disagrees
        mix = {8'h00, 8'h3C, 8'h3C};
        step(mix, 1'b0, 1'b0, 3'b000, all3(8'h3C), 3'b000, 1'b0, "R3 copy2 wrong");
        mix = {8'hA5, 8'h77, 8'hA5};
        step(mix, 1'b0, 1'b0, 3'b000, all3(8'hA5), 3'b000, 1'b0, "R3 copy1 wrong");
        mix = {8'h0F, 8'h0F, 8'hFF};
        step(mix, 1'b0, 1'b0, 3'b000, all3(8'h0F), 3'b000, 1'b0, "R3 copy0 wrong");

        // R2, R4: all three differ, bitwise vote E8
        mix = {8'hAA, 8'hCC, 8'hF0};
        step(mix, 1'b0, 1'b0, 3'b000, all3(vote(mix)), 3'b000, 1'b0, "R2 R4 three-way vote");

        // R5: capture old q and the voted value being loaded
        step(all3(a_val), 1'b0, 1'b0, 3'b000, all3(a_val), 3'b000, 1'b0, "R2 load A");
        mix = {b_val, b_val, 8'h00};
        img = {vote(mix), a_val};
        step(mix, 1'b1, 1'b0, 3'b000, all3(b_val), {3{img[0]}}, 1'b1, "R5 capture head");

        // R6, R8: shift out whole chain, q unaffected
        for (int k = 1; k < L; k++)
            step(mix, 1'b0, 1'b1, 3'b110, all3(b_val), {3{img[k]}}, 1'b1, "R6 R8 shift cell");
        step(mix, 1'b0, 1'b1, 3'b110, all3(b_val), 3'b110, 1'b1, "R9 per-copy scan-in");

        // R7: both enables high captures
        step(all3(c_val), 1'b1, 1'b1, 3'b000, all3(c_val), {3{b_val[0]}}, 1'b1, "R7 capture over shift");

        // R10: hold
        for (int k = 0; k < 3; k++)
            step(all3(c_val), 1'b0, 1'b0, 3'b111, all3(c_val), {3{b_val[0]}}, 1'b1, "R10 hold");
        step(all3(c_val), 1'b0, 1'b1, 3'b000, all3(c_val), {3{b_val[1]}}, 1'b1, "R6 R7 shift after capture");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule